// File: doc/BRIEF.md
# Lockable Cache Victim-Way Selector

This block chooses which way of a 4-way set-associative cache receives a refill, and it produces the new recency code for the set. Each set carries a 6-bit pairwise-order code. Every bit records which way of one pair was used longer ago. A small configuration register can pin ways 2 and 3 so that ordinary refills never evict them. A per-way load bit lets a prefetch issued in DSP mode be steered straight into a pinned way.

The cache controller presents one request per cycle. Each request carries the set's current recency code, a hit or miss indication (with the hit way), a prefetch flag and the DSP-mode flag. One cycle later the selector returns the chosen way and the updated code, which the controller writes back to the set. Tag storage, data storage and the bus refill live outside this block.

Top module: `cache_victim_sel`

## Requirements
- R1: The configuration register holds four fields: way-2 lock at bit 0, way-2 load at bit 1, way-3 lock at bit 8 and way-3 load at bit 9. All other bits read as zero. After reset all fields are zero.
- R2: A miss with the prefetch flag set, the DSP flag set, way-2 lock set and way-2 load set returns way 2, whatever the recency code is.
- R3: A miss with the prefetch flag set, the DSP flag set, way-3 lock set and way-3 load set, when R2 does not apply, returns way 3.
- R4: When R2 and R3 both apply, way 2 is returned. The sticky conflict flag rises one cycle later and stays high until reset.
- R5: Recency code bits name pairs as follows: bit 5 is ways 0/1, bit 4 is 0/2, bit 3 is 0/3, bit 2 is 1/2, bit 1 is 1/3 and bit 0 is 2/3. A 1 means the lower-numbered way of the pair is older. With only way-2 lock set, a non-forced miss returns the oldest of ways 0, 1 and 3 (for example, code 010100 gives way 3 and code 101001 gives way 0).
- R6: With only way-3 lock set, a non-forced miss returns the oldest of ways 0, 1 and 2 (for example, code 001011 gives way 2 and code 010100 gives way 1).
- R7: With both lock bits set, a non-forced miss returns the older of ways 0 and 1.
- R8: With no lock bit set, a miss returns the oldest of all four ways.
- R9: A code that is not a consistent total order of the four ways returns way 0 for every non-forced miss.
- R10: A locked way is never returned for a miss unless R2 or R3 applies.
- R11: A hit returns the hit way.
- R12: The returned code marks the returned way as newest: every pair bit that includes that way says the other way is older, and all other bits are copied unchanged.
- R13: Each request yields exactly one response one cycle later. No response appears in a cycle that follows an idle cycle.
- R14: A configuration write governs the very next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write value |
| cfg_rdata | output | 32 | Configuration register contents |
| req_valid | input | 1 | Request present this cycle |
| req_hit | input | 1 | 1 for a hit, 0 for a miss refill |
| req_hit_way | input | 2 | Way that hit |
| req_prefetch | input | 1 | Miss is a prefetch |
| dsp_mode | input | 1 | DSP-mode flag |
| lru_cur | input | 6 | Set's current recency code |
| rsp_valid | output | 1 | Response present |
| rsp_way | output | 2 | Selected way |
| rsp_lru | output | 6 | Updated recency code |
| load_conflict | output | 1 | Sticky flag: both forced-load paths requested at once |

## Verification
Every result is captured at the rising edge that samples the request: the way, the new code and the conflict flag. These results are therefore due one cycle after the request is presented. The bench drives each request on a falling edge and reads the response on the next falling edge. This puts each sample half a period after the capturing edge. A configuration write is read back on cfg_rdata at the same one-cycle point. The bench then issues a request immediately after the write, so that it can observe the one-cycle effect required by R14.

// File: rtl/cvs_pkg.sv
package cvs_pkg;

   typedef struct packed {
      logic load3;
      logic lock3;
      logic load2;
      logic lock2;
   } cvs_cfg_t;

   // Bit index holding the order of pair (lo, hi), lo < hi; pairs are
   // enumerated lexicographically from the most significant bit down.
   function automatic int unsigned cvs_pair_bit(int unsigned nw, int unsigned lo,
                                                int unsigned hi);
      int unsigned k;
      int unsigned res;
      k   = 0;
      res = 0;
      for (int unsigned a = 0; a < nw; a++) begin
         for (int unsigned b = a + 1; b < nw; b++) begin
            if (a == lo && b == hi) res = (nw * (nw - 1) / 2) - 1 - k;
            k++;
         end
      end
      return res;
   endfunction

endpackage

// File: rtl/cvs_cfg_reg.sv
module cvs_cfg_reg
   import cvs_pkg::*;
#(
   parameter int unsigned CTRL_W    = 32,
   parameter int unsigned LOCK2_BIT = 0,
   parameter int unsigned LOAD2_BIT = 1,
   parameter int unsigned LOCK3_BIT = 8,
   parameter int unsigned LOAD3_BIT = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [CTRL_W-1:0] wdata,
   output logic [CTRL_W-1:0] rdata,
   output cvs_cfg_t          cfg
);

   if (LOCK2_BIT >= CTRL_W || LOAD2_BIT >= CTRL_W ||
       LOCK3_BIT >= CTRL_W || LOAD3_BIT >= CTRL_W) begin : g_bad_pos
      $error("cvs_cfg_reg: field position outside register width");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (we) begin
         cfg.lock2 <= wdata[LOCK2_BIT];
         cfg.load2 <= wdata[LOAD2_BIT];
         cfg.lock3 <= wdata[LOCK3_BIT];
         cfg.load3 <= wdata[LOAD3_BIT];
      end
   end

   always_comb begin
      rdata            = '0;
      rdata[LOCK2_BIT] = cfg.lock2;
      rdata[LOAD2_BIT] = cfg.load2;
      rdata[LOCK3_BIT] = cfg.lock3;
      rdata[LOAD3_BIT] = cfg.load3;
   end

   logic unused_wbits;
   assign unused_wbits = ^wdata;

endmodule

// File: rtl/cvs_victim_dec.sv
module cvs_victim_dec
   import cvs_pkg::*;
#(
   parameter int unsigned NWAYS = 4,
   parameter int unsigned LRU_W = NWAYS * (NWAYS - 1) / 2,
   parameter int unsigned WAY_W = $clog2(NWAYS)
) (
   input  logic [LRU_W-1:0] lru,
   input  logic [NWAYS-1:0] allow,
   output logic [WAY_W-1:0] victim,
   output logic             order_ok
);

   localparam int unsigned CNT_W = $clog2(NWAYS);

   // older[w][x] : way w was used before way x
   logic [NWAYS-1:0][NWAYS-1:0] older;
   logic [NWAYS-1:0]            cand;
   logic [CNT_W-1:0]            rank [NWAYS];

   for (genvar w = 0; w < NWAYS; w++) begin : g_row
      for (genvar x = 0; x < NWAYS; x++) begin : g_col
         if (w == x) begin : g_self
            assign older[w][x] = 1'b0;
         end else if (w < x) begin : g_fwd
            assign older[w][x] = lru[cvs_pair_bit(NWAYS, w, x)];
         end else begin : g_rev
            assign older[w][x] = ~lru[cvs_pair_bit(NWAYS, x, w)];
         end
      end
      assign cand[w] = allow[w] & (&(older[w] | ~allow | (NWAYS'(1) << w)));
   end

   always_comb begin
      for (int w = 0; w < NWAYS; w++) rank[w] = CNT_W'($countones(older[w]));
   end

   // a consistent total order gives every way a distinct rank
   always_comb begin
      order_ok = 1'b1;
      for (int a = 0; a < NWAYS; a++) begin
         for (int b = a + 1; b < NWAYS; b++) begin
            if (rank[a] == rank[b]) order_ok = 1'b0;
         end
      end
   end

   always_comb begin
      victim = '0;
      for (int w = NWAYS - 1; w >= 0; w--) begin
         if (cand[w]) victim = WAY_W'(w);
      end
      if (!order_ok) victim = '0;
   end

endmodule

// File: rtl/cvs_mru_upd.sv
module cvs_mru_upd
   import cvs_pkg::*;
#(
   parameter int unsigned NWAYS = 4,
   parameter int unsigned LRU_W = NWAYS * (NWAYS - 1) / 2,
   parameter int unsigned WAY_W = $clog2(NWAYS)
) (
   input  logic [LRU_W-1:0] lru_in,
   input  logic [WAY_W-1:0] way,
   output logic [LRU_W-1:0] lru_out
);

   for (genvar lo = 0; lo < NWAYS; lo++) begin : g_lo
      for (genvar hi = lo + 1; hi < NWAYS; hi++) begin : g_hi
         localparam int unsigned P = cvs_pair_bit(NWAYS, lo, hi);
         assign lru_out[P] = (way == WAY_W'(lo)) ? 1'b0 :
                             (way == WAY_W'(hi)) ? 1'b1 : lru_in[P];
      end
   end

endmodule

// File: rtl/cache_victim_sel.sv
module cache_victim_sel
   import cvs_pkg::*;
#(
   parameter int unsigned NWAYS     = 4,
   parameter int unsigned CTRL_W    = 32,
   parameter int unsigned LOCK_A    = 2,
   parameter int unsigned LOCK_B    = 3,
   parameter int unsigned LOCK2_BIT = 0,
   parameter int unsigned LOAD2_BIT = 1,
   parameter int unsigned LOCK3_BIT = 8,
   parameter int unsigned LOAD3_BIT = 9,
   parameter int unsigned WAY_W     = $clog2(NWAYS),
   parameter int unsigned LRU_W     = NWAYS * (NWAYS - 1) / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CTRL_W-1:0] cfg_wdata,
   output logic [CTRL_W-1:0] cfg_rdata,
   input  logic              req_valid,
   input  logic              req_hit,
   input  logic [WAY_W-1:0]  req_hit_way,
   input  logic              req_prefetch,
   input  logic              dsp_mode,
   input  logic [LRU_W-1:0]  lru_cur,
   output logic              rsp_valid,
   output logic [WAY_W-1:0]  rsp_way,
   output logic [LRU_W-1:0]  rsp_lru,
   output logic              load_conflict
);

   if (NWAYS < 2) begin : g_bad_ways
      $error("cache_victim_sel: need at least two ways");
   end
   if (LOCK_A >= NWAYS || LOCK_B >= NWAYS || LOCK_A == LOCK_B) begin : g_bad_lock
      $error("cache_victim_sel: lockable ways must be distinct and present");
   end
   if (WAY_W != $clog2(NWAYS) || LRU_W != NWAYS * (NWAYS - 1) / 2) begin : g_bad_w
      $error("cache_victim_sel: derived widths overridden inconsistently");
   end

   cvs_cfg_t         cfg;
   logic [NWAYS-1:0] allow;
   logic [WAY_W-1:0] dec_way;
   logic [WAY_W-1:0] fill_way;
   logic [WAY_W-1:0] sel_way;
   logic [LRU_W-1:0] next_lru;
   logic             dec_ok;
   logic             force_a;
   logic             force_b;
   logic             conflict;

   cvs_cfg_reg #(
      .CTRL_W   (CTRL_W),
      .LOCK2_BIT(LOCK2_BIT),
      .LOAD2_BIT(LOAD2_BIT),
      .LOCK3_BIT(LOCK3_BIT),
      .LOAD3_BIT(LOAD3_BIT)
   ) u_cfg (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (cfg_we),
      .wdata(cfg_wdata),
      .rdata(cfg_rdata),
      .cfg  (cfg)
   );

   always_comb begin
      allow         = '1;
      allow[LOCK_A] = ~cfg.lock2;
      allow[LOCK_B] = ~cfg.lock3;
   end

   cvs_victim_dec #(
      .NWAYS(NWAYS),
      .LRU_W(LRU_W),
      .WAY_W(WAY_W)
   ) u_dec (
      .lru     (lru_cur),
      .allow   (allow),
      .victim  (dec_way),
      .order_ok(dec_ok)
   );

   assign force_a  = req_prefetch & dsp_mode & cfg.lock2 & cfg.load2;
   assign force_b  = req_prefetch & dsp_mode & cfg.lock3 & cfg.load3;
   assign conflict = req_valid & ~req_hit & force_a & force_b;

   always_comb begin
      if (force_a)      fill_way = WAY_W'(LOCK_A);
      else if (force_b) fill_way = WAY_W'(LOCK_B);
      else              fill_way = dec_way;
      sel_way = req_hit ? req_hit_way : fill_way;
   end

   cvs_mru_upd #(
      .NWAYS(NWAYS),
      .LRU_W(LRU_W),
      .WAY_W(WAY_W)
   ) u_upd (
      .lru_in (lru_cur),
      .way    (sel_way),
      .lru_out(next_lru)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_way       <= '0;
         rsp_lru       <= '0;
         load_conflict <= 1'b0;
      end else begin
         rsp_valid     <= req_valid;
         load_conflict <= load_conflict | conflict;
         if (req_valid) begin
            rsp_way <= sel_way;
            rsp_lru <= next_lru;
         end
      end
   end

   logic unused_dec;
   assign unused_dec = dec_ok;

endmodule

// File: rtl/cache_victim_sel_chk.sv
module cache_victim_sel_chk
   import cvs_pkg::*;
#(
   parameter int unsigned NWAYS     = 4,
   parameter int unsigned CTRL_W    = 32,
   parameter int unsigned LOCK_A    = 2,
   parameter int unsigned LOCK_B    = 3,
   parameter int unsigned LOCK2_BIT = 0,
   parameter int unsigned LOAD2_BIT = 1,
   parameter int unsigned LOCK3_BIT = 8,
   parameter int unsigned LOAD3_BIT = 9,
   parameter int unsigned WAY_W     = $clog2(NWAYS),
   parameter int unsigned LRU_W     = NWAYS * (NWAYS - 1) / 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [CTRL_W-1:0] cfg_wdata,
   input logic [CTRL_W-1:0] cfg_rdata,
   input logic              req_valid,
   input logic              req_hit,
   input logic [WAY_W-1:0]  req_hit_way,
   input logic              req_prefetch,
   input logic              dsp_mode,
   input logic [LRU_W-1:0]  lru_cur,
   input logic              rsp_valid,
   input logic [WAY_W-1:0]  rsp_way,
   input logic [LRU_W-1:0]  rsp_lru,
   input logic              load_conflict
);

   localparam logic [CTRL_W-1:0] FIELD_MASK =
      (CTRL_W'(1) << LOCK2_BIT) | (CTRL_W'(1) << LOAD2_BIT) |
      (CTRL_W'(1) << LOCK3_BIT) | (CTRL_W'(1) << LOAD3_BIT);

   function automatic logic newest(logic [LRU_W-1:0] code, logic [WAY_W-1:0] way);
      logic ok;
      ok = 1'b1;
      for (int x = 0; x < NWAYS; x++) begin
         if (x < int'(way))      ok = ok & code[cvs_pair_bit(NWAYS, x, int'(way))];
         else if (x > int'(way)) ok = ok & ~code[cvs_pair_bit(NWAYS, int'(way), x)];
      end
      return ok;
   endfunction

   logic miss_req, push_a, push_b;
   assign miss_req = req_valid & ~req_hit;
   assign push_a   = req_prefetch & dsp_mode & cfg_rdata[LOCK2_BIT] & cfg_rdata[LOAD2_BIT];
   assign push_b   = req_prefetch & dsp_mode & cfg_rdata[LOCK3_BIT] & cfg_rdata[LOAD3_BIT];

   AST_CFG_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata & ~FIELD_MASK) == '0);                                          // R1
   AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_req && push_a) |=> (rsp_way == WAY_W'(LOCK_A)));                     // R2
   AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_req && !push_a && push_b) |=> (rsp_way == WAY_W'(LOCK_B)));          // R3
   AST_CONFLICT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      load_conflict |=> load_conflict);                                          // R4
   AST_CONFLICT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_req && push_a && push_b) |=> load_conflict);                         // R4
   AST_LOCK_A_SPARED: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_req && cfg_rdata[LOCK2_BIT] && !push_a) |=> (rsp_way != WAY_W'(LOCK_A))); // R10
   AST_LOCK_B_SPARED: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_req && cfg_rdata[LOCK3_BIT] && !push_b) |=> (rsp_way != WAY_W'(LOCK_B))); // R10
   AST_HIT_WAY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_hit) |=> (rsp_way == $past(req_hit_way)));               // R11
   AST_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> newest(rsp_lru, rsp_way));                                   // R12
   AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);                                                  // R13
   AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);                                                // R13

   logic unused_chk;
   assign unused_chk = ^{cfg_we, cfg_wdata, lru_cur};

endmodule

bind cache_victim_sel cache_victim_sel_chk #(
   .NWAYS    (NWAYS),
   .CTRL_W   (CTRL_W),
   .LOCK_A   (LOCK_A),
   .LOCK_B   (LOCK_B),
   .LOCK2_BIT(LOCK2_BIT),
   .LOAD2_BIT(LOAD2_BIT),
   .LOCK3_BIT(LOCK3_BIT),
   .LOAD3_BIT(LOAD3_BIT),
   .WAY_W    (WAY_W),
   .LRU_W    (LRU_W)
) u_chk (.*);

// File: tb/cache_victim_sel_tb_top.sv
`timescale 1ns/1ps
module cache_victim_sel_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        req_valid = 1'b0;
   logic        req_hit = 1'b0;
   logic [1:0]  req_hit_way = '0;
   logic        req_prefetch = 1'b0;
   logic        dsp_mode = 1'b0;
   logic [5:0]  lru_cur = '0;
   logic        rsp_valid;
   logic [1:0]  rsp_way;
   logic [5:0]  rsp_lru;
   logic        load_conflict;

   int checks = 0;
   int errors = 0;
   bit err_exp = 1'b0;

   always #2.5 clk = ~clk;

   cache_victim_sel dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_hit(req_hit),
      .req_hit_way(req_hit_way), .req_prefetch(req_prefetch), .dsp_mode(dsp_mode),
      .lru_cur(lru_cur), .rsp_valid(rsp_valid), .rsp_way(rsp_way),
      .rsp_lru(rsp_lru), .load_conflict(load_conflict)
   );

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // pair (i,j), i<j, to code bit as listed in R5
   function automatic int bpos(int i, int j);
      case ({i[1:0], j[1:0]})
         4'b0001: return 5;
         4'b0010: return 4;
         4'b0011: return 3;
         4'b0110: return 2;
         4'b0111: return 1;
         default: return 0;
      endcase
   endfunction

   // search all 24 age orders; pos[w]=0 is the oldest way
   function automatic int ref_victim(logic [5:0] code, bit l2, bit l3, output bit valid);
      int pos [4];
      logic [5:0] w;
      valid = 1'b0;
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++)
            for (int c = 0; c < 4; c++)
               for (int d = 0; d < 4; d++) begin
                  if (a != b && a != c && a != d && b != c && b != d && c != d) begin
                     pos[0] = a; pos[1] = b; pos[2] = c; pos[3] = d;
                     w = '0;
                     for (int i = 0; i < 4; i++)
                        for (int j = i + 1; j < 4; j++)
                           w[bpos(i, j)] = (pos[i] < pos[j]);
                     if (w == code) begin
                        int best;
                        best  = -1;
                        valid = 1'b1;
                        for (int v = 0; v < 4; v++) begin
                           if ((v != 2 || !l2) && (v != 3 || !l3) &&
                               (best < 0 || pos[v] < pos[best])) best = v;
                        end
                        return best;
                     end
                  end
               end
      return 0;
   endfunction

   function automatic logic [5:0] ref_lru(logic [5:0] code, int way);
      logic [5:0] r;
      r = code;
      for (int i = 0; i < 4; i++)
         for (int j = i + 1; j < 4; j++) begin
            if (i == way) r[bpos(i, j)] = 1'b0;
            else if (j == way) r[bpos(i, j)] = 1'b1;
         end
      return r;
   endfunction

   task automatic wr_cfg(logic [31:0] v);
      cfg_we    = 1'b1;
      cfg_wdata = v;
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic issue(bit hit, int hway, bit pref, bit dsp, logic [5:0] code);
      req_valid    = 1'b1;
      req_hit      = hit;
      req_hit_way  = 2'(hway);
      req_prefetch = pref;
      dsp_mode     = dsp;
      lru_cur      = code;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic miss_check(bit l2, bit ld2, bit l3, bit ld3, bit pref, bit dsp,
                             logic [5:0] code);
      bit f2, f3, valid;
      int exp;
      string tag;
      f2  = pref & dsp & l2 & ld2;
      f3  = pref & dsp & l3 & ld3;
      exp = ref_victim(code, l2, l3, valid);
      if (f2 && f3)      begin exp = 2; tag = "R4"; end
      else if (f2)       begin exp = 2; tag = "R2"; end
      else if (f3)       begin exp = 3; tag = "R3"; end
      else if (!valid)   tag = "R9";
      else if (l2 && l3) tag = "R7";
      else if (l2)       tag = "R5";
      else if (l3)       tag = "R6";
      else               tag = "R8";
      err_exp = err_exp | (f2 & f3);
      issue(1'b0, 0, pref, dsp, code);
      chk(rsp_valid == 1'b1, "R13", "rsp_valid", int'(rsp_valid), 1);
      chk(int'(rsp_way) == exp, tag, $sformatf("way code=%06b", code), int'(rsp_way), exp);
      if (!f2 && !f3) begin
         if (l2) chk(rsp_way != 2'd2, "R10", "locked way 2 chosen", int'(rsp_way), 2);
         if (l3) chk(rsp_way != 2'd3, "R10", "locked way 3 chosen", int'(rsp_way), 3);
      end
      chk(rsp_lru == ref_lru(code, exp), "R12", "lru", int'(rsp_lru), int'(ref_lru(code, exp)));
      chk(load_conflict == err_exp, "R4", "conflict flag", int'(load_conflict), int'(err_exp));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cfg_rdata == 32'h0, "R1", "reset cfg", int'(cfg_rdata), 0);
      chk(rsp_valid == 1'b0, "R13", "reset rsp_valid", int'(rsp_valid), 0);
      chk(load_conflict == 1'b0, "R4", "reset flag", int'(load_conflict), 0);

      wr_cfg(32'hFFFF_FFFF);
      chk(cfg_rdata == 32'h0000_0303, "R1", "all-ones readback", int'(cfg_rdata), 32'h303);
      wr_cfg(32'h0000_0102);
      chk(cfg_rdata == 32'h0000_0102, "R1", "mixed readback", int'(cfg_rdata), 32'h102);

      // table spot checks
      wr_cfg(32'h0000_0001);
      issue(1'b0, 0, 1'b0, 1'b0, 6'b010100);
      chk(rsp_way == 2'd3, "R5", "lock2 010100", int'(rsp_way), 3);
      issue(1'b0, 0, 1'b0, 1'b0, 6'b101001);
      chk(rsp_way == 2'd0, "R5", "lock2 101001", int'(rsp_way), 0);
      wr_cfg(32'h0000_0100);
      issue(1'b0, 0, 1'b0, 1'b0, 6'b001011);
      chk(rsp_way == 2'd2, "R6", "lock3 001011", int'(rsp_way), 2);
      issue(1'b0, 0, 1'b0, 1'b0, 6'b010100);
      chk(rsp_way == 2'd1, "R6", "lock3 010100", int'(rsp_way), 1);

      // a write steers the very next request
      issue(1'b0, 0, 1'b0, 1'b0, 6'b000000);
      chk(rsp_way == 2'd2, "R14", "lock3 before write", int'(rsp_way), 2);
      wr_cfg(32'h0);
      issue(1'b0, 0, 1'b0, 1'b0, 6'b000000);
      chk(rsp_way == 2'd3, "R14", "right after unlock", int'(rsp_way), 3);

      // idle cycle gives no response
      @(posedge clk);
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R13", "idle rsp_valid", int'(rsp_valid), 0);

      // full sweep: configuration x code x prefetch x dsp
      for (int c = 0; c < 16; c++) begin
         bit l2, ld2, l3, ld3;
         l2 = c[0]; ld2 = c[1]; l3 = c[2]; ld3 = c[3];
         wr_cfg({22'b0, ld3, l3, 6'b0, ld2, l2});
         for (int code = 0; code < 64; code++)
            for (int m = 0; m < 4; m++)
               miss_check(l2, ld2, l3, ld3, m[0], m[1], 6'(code));
      end

      // hits, and the flag stays raised
      wr_cfg(32'h0000_0303);
      for (int code = 0; code < 64; code++)
         for (int hw = 0; hw < 4; hw++) begin
            issue(1'b1, hw, 1'b0, 1'b0, 6'(code));
            chk(int'(rsp_way) == hw, "R11", "hit way", int'(rsp_way), hw);
            chk(rsp_lru == ref_lru(6'(code), hw), "R12", "hit lru",
                int'(rsp_lru), int'(ref_lru(6'(code), hw)));
            chk(load_conflict == 1'b1, "R4", "flag sticky", int'(load_conflict), 1);
         end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule